// File: doc/BRIEF.md
# Video Processor Command Port

This block is the control-port front end of a tile-based video processor. A host CPU writes 16-bit words to it. The block sorts each word into one of two kinds. It is either a one-word register write, or one half of a two-word command that places an access address and an access code. It keeps a 16-bit address, a 6-bit access code and a small 8-bit register file. Between commands it holds the top two address bits in a latch.

The block also watches the DMA-enable bit and the DMA-type field in the register file. When the second command word carries the DMA request bit and DMA is enabled, it issues a one-cycle start with a kind field. A fill request is not started at once: it is armed, and it waits for the next data-port write. A status read returns the FIFO-empty flag and a sticky sprite-collision flag. The read clears that flag and the pending state. The memories, the DMA engine and the raster timing sit outside this block.

Top module: `vidCmdPort`

## Requirements
- R1: After reset the address, code, address latch, pending flag, register file, collision flag, fill arm, register-write strobe and DMA start are all zero.
- R2: A control write with no command pending and data bits 15:14 equal to 2'b10 is a register write. One cycle later regWrStb pulses, with regWrIdx = data[12:8] and regWrData = data[7:0]. The register file holds that value from then on, and the pending flag stays low.
- R3: A control write with no command pending and data bits 15:14 not equal to 2'b10 sets the pending flag.
- R4: Every first word, register writes included, sets address[13:0] = data[13:0] and code[1:0] = data[15:14]. Address[15:14] take the value of the latch, and code[5:2] are kept.
- R5: A control write while a command is pending is a second word. It clears pending and sets address[15:14] = data[1:0] and code[5:2] = data[7:4]. Address[13:0] and code[1:0] are kept. Data[1:0] is also stored into the address latch.
- R6: A second word whose new code bit 5 (data bit 7) is set, while register 1 bit 4 is set, pulses dmaStart one cycle later. dmaKind is taken from register 23 bits 7:6: 2'b00 or 2'b01 gives 2'b00 (bus transfer), 2'b10 gives 2'b10 (fill) and 2'b11 gives 2'b11 (copy). Otherwise dmaStart stays low.
- R7: A fill start raises fillArmed. It stays high through control writes and idle cycles, and it falls in the cycle after the next data-port write.
- R8: statusData has bit 9 set and the collision flag at bit 5, with every other bit zero. collisionHit sets the flag. A status read clears the flag and the pending flag. A hit in the same cycle as a read leaves the flag set.
- R9: A data-port read or write clears the pending flag.
- R10: A register write to index 24..31 is ignored. No strobe is given and the register file is left unchanged. Reading those indices through regRdIdx returns zero.
- R11: When a control write coincides with a status read or a data-port access, the control write decides the pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWrEn | input | 1 | Control-port write |
| ctrlWrData | input | 16 | Control-port write word |
| statRdEn | input | 1 | Status read |
| dataRdEn | input | 1 | Data-port read |
| dataWrEn | input | 1 | Data-port write |
| collisionHit | input | 1 | Sprite collision event from the renderer |
| regRdIdx | input | 5 | Register file read index |
| regRdData | output | 8 | Register file read value (zero for index 24 and up) |
| statusData | output | 16 | Status word |
| regWrStb | output | 1 | Register write pulse |
| regWrIdx | output | 5 | Register write index |
| regWrData | output | 8 | Register write value |
| addrOut | output | 16 | Current access address |
| codeOut | output | 6 | Current access code |
| pendingOut | output | 1 | Second command word expected |
| dmaStart | output | 1 | DMA start pulse |
| dmaKind | output | 2 | DMA kind given with dmaStart |
| fillArmed | output | 1 | Fill request waiting for a data write |

## Verification
A stuck or wrongly cleared pending flag shows at once: the next control word takes the wrong path, and addrOut and codeOut go wrong in the cycle after that write. A bad address latch shows only on the next first word, as wrong addrOut[15:14]. A wrong register-file entry stays hidden until a DMA request reads it, or until regRdIdx selects it. For that reason the bench reads registers back on every cycle and checks every output against its model on every clock.

// File: rtl/vcp_pkg.sv
package vcp_pkg;
  typedef enum logic [1:0] {
    DMA_BUS  = 2'b00,
    DMA_FILL = 2'b10,
    DMA_COPY = 2'b11
  } dmaKindT;

  typedef struct packed {
    logic firstWord;
    logic secondWord;
    logic regWrite;
  } ctlStrobeT;
endpackage

// File: rtl/vcpCtrl.sv
module vcpCtrl
  import vcp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctrlWrEn,
  input  logic [1:0] ctrlTop,
  input  logic       statRdEn,
  input  logic       dataRdEn,
  input  logic       dataWrEn,
  output ctlStrobeT  stb,
  output logic       pendingOut
);
  localparam logic [1:0] REG_WR_TAG = 2'b10;

  logic pending;
  logic clrPending;

  always_comb begin
    stb = '0;
    clrPending = 1'b0;
    if (ctrlWrEn) begin
      if (pending) begin
        stb.secondWord = 1'b1;
      end else begin
        stb.firstWord = 1'b1;
        stb.regWrite  = (ctrlTop == REG_WR_TAG);
      end
    end else if (statRdEn || dataRdEn || dataWrEn) begin
      clrPending = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= 1'b0;
    end else if (stb.firstWord && !stb.regWrite) begin
      pending <= 1'b1;
    end else if (stb.secondWord || clrPending) begin
      pending <= 1'b0;
    end
  end

  assign pendingOut = pending;
endmodule

// File: rtl/vcpDatapath.sv
module vcpDatapath
  import vcp_pkg::*;
#(
  parameter int NUM_REGS     = 24,
  parameter int IDX_W        = 5,
  parameter int DMA_EN_REG   = 1,
  parameter int DMA_EN_BIT   = 4,
  parameter int DMA_MODE_REG = 23
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobeT        stb,
  input  logic [15:0]      wrData,
  input  logic             statRdEn,
  input  logic             dataWrEn,
  input  logic             collisionHit,
  input  logic [IDX_W-1:0] regRdIdx,
  output logic [7:0]       regRdData,
  output logic [15:0]      statusData,
  output logic             regWrStb,
  output logic [IDX_W-1:0] regWrIdx,
  output logic [7:0]       regWrData,
  output logic [15:0]      addrOut,
  output logic [5:0]       codeOut,
  output logic             dmaStart,
  output logic [1:0]       dmaKind,
  output logic             fillArmed
);
  localparam int FIFO_EMPTY_BIT = 9;
  localparam int COLL_BIT       = 5;
  localparam int LOW_ADDR_W     = 14;
  localparam logic [IDX_W-1:0] REG_LIMIT = IDX_W'(NUM_REGS);

  logic [7:0]  regs [NUM_REGS];
  logic [1:0]  addrLatch;
  logic        collFlag;
  logic [IDX_W-1:0] wrIdx;
  logic        idxOk;
  logic        dmaReq;
  dmaKindT     nextKind;

  assign wrIdx  = wrData[8 +: IDX_W];
  assign idxOk  = (wrIdx < REG_LIMIT);
  assign dmaReq = stb.secondWord && wrData[7] && regs[DMA_EN_REG][DMA_EN_BIT];

  always_comb begin
    unique case (regs[DMA_MODE_REG][7:6])
      2'b10:   nextKind = DMA_FILL;
      2'b11:   nextKind = DMA_COPY;
      default: nextKind = DMA_BUS;
    endcase
  end

  generate
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rstN) begin
          regs[i] <= '0;
        end else if (stb.regWrite && wrIdx == IDX_W'(i)) begin
          regs[i] <= wrData[7:0];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrOut   <= '0;
      codeOut   <= '0;
      addrLatch <= '0;
      regWrStb  <= 1'b0;
      regWrIdx  <= '0;
      regWrData <= '0;
      dmaStart  <= 1'b0;
      dmaKind   <= DMA_BUS;
      fillArmed <= 1'b0;
      collFlag  <= 1'b0;
    end else begin
      regWrStb <= 1'b0;
      dmaStart <= 1'b0;
      if (stb.firstWord) begin
        addrOut <= {addrLatch, wrData[LOW_ADDR_W-1:0]};
        codeOut <= {codeOut[5:2], wrData[15:14]};
        if (stb.regWrite && idxOk) begin
          regWrStb  <= 1'b1;
          regWrIdx  <= wrIdx;
          regWrData <= wrData[7:0];
        end
      end
      if (stb.secondWord) begin
        addrOut[15:14] <= wrData[1:0];
        addrLatch      <= wrData[1:0];
        codeOut[5:2]   <= wrData[7:4];
      end
      if (dmaReq) begin
        dmaStart <= 1'b1;
        dmaKind  <= nextKind;
      end
      if (dmaReq && nextKind == DMA_FILL) begin
        fillArmed <= 1'b1;
      end else if (dataWrEn) begin
        fillArmed <= 1'b0;
      end
      if (collisionHit) begin
        collFlag <= 1'b1;
      end else if (statRdEn) begin
        collFlag <= 1'b0;
      end
    end
  end

  always_comb begin
    regRdData = '0;
    if (regRdIdx < REG_LIMIT) begin
      regRdData = regs[regRdIdx];
    end
    statusData = '0;
    statusData[FIFO_EMPTY_BIT] = 1'b1;
    statusData[COLL_BIT]       = collFlag;
  end
endmodule

// File: rtl/vidCmdPort.sv
module vidCmdPort
  import vcp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ctrlWrEn,
  input  logic [15:0] ctrlWrData,
  input  logic        statRdEn,
  input  logic        dataRdEn,
  input  logic        dataWrEn,
  input  logic        collisionHit,
  input  logic [4:0]  regRdIdx,
  output logic [7:0]  regRdData,
  output logic [15:0] statusData,
  output logic        regWrStb,
  output logic [4:0]  regWrIdx,
  output logic [7:0]  regWrData,
  output logic [15:0] addrOut,
  output logic [5:0]  codeOut,
  output logic        pendingOut,
  output logic        dmaStart,
  output logic [1:0]  dmaKind,
  output logic        fillArmed
);
  ctlStrobeT stb;

  vcpCtrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .ctrlWrEn   (ctrlWrEn),
    .ctrlTop    (ctrlWrData[15:14]),
    .statRdEn   (statRdEn),
    .dataRdEn   (dataRdEn),
    .dataWrEn   (dataWrEn),
    .stb        (stb),
    .pendingOut (pendingOut)
  );

  vcpDatapath #(
    .NUM_REGS (24),
    .IDX_W    (5)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .wrData       (ctrlWrData),
    .statRdEn     (statRdEn),
    .dataWrEn     (dataWrEn),
    .collisionHit (collisionHit),
    .regRdIdx     (regRdIdx),
    .regRdData    (regRdData),
    .statusData   (statusData),
    .regWrStb     (regWrStb),
    .regWrIdx     (regWrIdx),
    .regWrData    (regWrData),
    .addrOut      (addrOut),
    .codeOut      (codeOut),
    .dmaStart     (dmaStart),
    .dmaKind      (dmaKind),
    .fillArmed    (fillArmed)
  );
endmodule

// File: rtl/vidCmdPortChk.sv
module vidCmdPortChk #(
  parameter int NUM_REGS = 24
) (
  input logic        clk,
  input logic        rstN,
  input logic        ctrlWrEn,
  input logic [15:0] ctrlWrData,
  input logic        statRdEn,
  input logic        dataRdEn,
  input logic        dataWrEn,
  input logic        regWrStb,
  input logic [4:0]  regWrIdx,
  input logic [15:0] addrOut,
  input logic        pendingOut,
  input logic        dmaStart,
  input logic        fillArmed
);
  assert_first_sets_pend_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWrEn && !pendingOut && ctrlWrData[15:14] != 2'b10 |=> pendingOut);

  assert_second_keeps_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWrEn && pendingOut |=> !pendingOut && addrOut[13:0] == $past(addrOut[13:0]));

  assert_dma_after_second_R6: assert property (@(posedge clk) disable iff (!rstN)
    dmaStart |-> $past(ctrlWrEn && pendingOut));

  assert_fill_held_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(fillArmed) |-> $past(dataWrEn));

  assert_stat_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    statRdEn && !ctrlWrEn |=> !pendingOut);

  assert_data_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    (dataRdEn || dataWrEn) && !ctrlWrEn |=> !pendingOut);

  assert_idx_range_R10: assert property (@(posedge clk) disable iff (!rstN)
    regWrStb |-> regWrIdx < 5'(NUM_REGS));
endmodule

bind vidCmdPort vidCmdPortChk #(.NUM_REGS(24)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .ctrlWrEn   (ctrlWrEn),
  .ctrlWrData (ctrlWrData),
  .statRdEn   (statRdEn),
  .dataRdEn   (dataRdEn),
  .dataWrEn   (dataWrEn),
  .regWrStb   (regWrStb),
  .regWrIdx   (regWrIdx),
  .addrOut    (addrOut),
  .pendingOut (pendingOut),
  .dmaStart   (dmaStart),
  .fillArmed  (fillArmed)
);

// File: tb/vidCmdPort_tb.sv
module vidCmdPort_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctrlWrEn = 1'b0;
  logic [15:0] ctrlWrData = '0;
  logic        statRdEn = 1'b0;
  logic        dataRdEn = 1'b0;
  logic        dataWrEn = 1'b0;
  logic        collisionHit = 1'b0;
  logic [4:0]  regRdIdx = '0;
  logic [7:0]  regRdData;
  logic [15:0] statusData;
  logic        regWrStb;
  logic [4:0]  regWrIdx;
  logic [7:0]  regWrData;
  logic [15:0] addrOut;
  logic [5:0]  codeOut;
  logic        pendingOut;
  logic        dmaStart;
  logic [1:0]  dmaKind;
  logic        fillArmed;

  always #(CLK_PERIOD/2) clk = ~clk;

  vidCmdPort dut_i (.*);

  int nCmp = 0;
  int nBad = 0;
  bit done = 0;

  int mAddr, mCode, mLatch, mPend, mFill, mColl;
  int mStb, mIdx, mData, mDma, mKind;
  int mRegs [24];

  task automatic chk(string req, string what, int act, int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int regModel(int idx);
    return (idx < 24) ? mRegs[idx] : 0;
  endfunction

  task automatic compareAll(string req);
    chk(req, "addrOut", int'(addrOut), mAddr);
    chk(req, "codeOut", int'(codeOut), mCode);
    chk(req, "pendingOut", int'(pendingOut), mPend);
    chk(req, "fillArmed", int'(fillArmed), mFill);
    chk(req, "regWrStb", int'(regWrStb), mStb);
    if (mStb != 0) begin
      chk(req, "regWrIdx", int'(regWrIdx), mIdx);
      chk(req, "regWrData", int'(regWrData), mData);
    end
    chk(req, "dmaStart", int'(dmaStart), mDma);
    if (mDma != 0) chk(req, "dmaKind", int'(dmaKind), mKind);
    chk(req, "regRdData", int'(regRdData), regModel(int'(regRdIdx)));
    chk(req, "statusData", int'(statusData), 32'h200 | (mColl << 5));
  endtask

  // one clock: drive at negedge, model the edge, compare at the next negedge
  task automatic cyc(string req, bit cw, int cd, bit sr, bit dr, bit dw, bit hit, int rdIdx);
    bit setFill;
    int k;
    ctrlWrEn = cw; ctrlWrData = 16'(cd); statRdEn = sr; dataRdEn = dr;
    dataWrEn = dw; collisionHit = hit; regRdIdx = 5'(rdIdx);
    #1;
    chk(req, "statusData pre-edge", int'(statusData), 32'h200 | (mColl << 5));
    chk(req, "regRdData pre-edge", int'(regRdData), regModel(rdIdx));
    mStb = 0; mDma = 0; setFill = 0;
    if (cw) begin
      if (mPend != 0) begin
        mPend = 0;
        mAddr = (mAddr & 32'h3FFF) | ((cd & 3) << 14);
        mLatch = cd & 3;
        mCode = (mCode & 3) | (((cd >> 4) & 15) << 2);
        if (((cd >> 7) & 1) != 0 && ((mRegs[1] >> 4) & 1) != 0) begin
          mDma = 1;
          k = (mRegs[23] >> 6) & 3;
          mKind = (k == 1) ? 0 : k;
          if (k == 2) setFill = 1;
        end
      end else begin
        mAddr = (mLatch << 14) | (cd & 32'h3FFF);
        mCode = (mCode & 32'h3C) | ((cd >> 14) & 3);
        if (((cd >> 14) & 3) == 2) begin
          k = (cd >> 8) & 31;
          if (k < 24) begin
            mRegs[k] = cd & 255; mStb = 1; mIdx = k; mData = cd & 255;
          end
        end else begin
          mPend = 1;
        end
      end
    end else if (sr || dr || dw) begin
      mPend = 0;
    end
    if (setFill) mFill = 1;
    else if (dw) mFill = 0;
    if (hit) mColl = 1;
    else if (sr) mColl = 0;
    @(posedge clk);
    @(negedge clk);
    compareAll(req);
    ctrlWrEn = 0; statRdEn = 0; dataRdEn = 0; dataWrEn = 0; collisionHit = 0;
  endtask

  task automatic ctl(string req, int cd, int rdIdx);
    cyc(req, 1, cd, 0, 0, 0, 0, rdIdx);
  endtask

  task automatic idle(string req, int rdIdx);
    cyc(req, 0, 0, 0, 0, 0, 0, rdIdx);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    mAddr = 0; mCode = 0; mLatch = 0; mPend = 0; mFill = 0; mColl = 0;
    mStb = 0; mIdx = 0; mData = 0; mDma = 0; mKind = 0;
    foreach (mRegs[i]) mRegs[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    compareAll("R1");
    idle("R1", 1);
    idle("R1", 23);

    // R2: register writes (reg1 = DMA enable, reg23 = fill type)
    ctl("R2", 16'h8110, 1);
    ctl("R2", 16'h9780, 23);
    ctl("R2", 16'h8A5C, 10);

    // R10: index 25 and 31 ignored, nothing changes
    ctl("R10", 16'h9955, 25);
    ctl("R10", 16'h9FAA, 31);
    idle("R10", 1);

    // R3/R4: first word sets pending, loads low address and code[1:0]
    ctl("R3", 16'h4123, 1);
    // R5/R6/R7: second word with code bit5 -> fill armed
    ctl("R5", 16'h0092, 23);
    idle("R7", 0);
    // R4: next first word reuses latch (bits 15:14 = 2)
    ctl("R4", 16'h0005, 0);
    // R9: data read clears pending
    cyc("R9", 0, 0, 0, 1, 0, 0, 0);
    chk("R7", "fill still armed", int'(fillArmed), 1);
    // R7: data write consumes the fill arm
    cyc("R7", 0, 0, 0, 0, 1, 0, 0);

    // R6: copy
    ctl("R6", 16'h97C0, 23);
    ctl("R6", 16'h7FFF, 0);
    ctl("R6", 16'h00A1, 0);
    // R6: bus (01 -> 00)
    ctl("R6", 16'h9740, 23);
    ctl("R6", 16'h0010, 0);
    ctl("R6", 16'h00F3, 0);
    // R6: code bit5 clear -> no start
    ctl("R6", 16'h0200, 0);
    ctl("R6", 16'h0060, 0);
    // R6: DMA disabled -> no start
    ctl("R6", 16'h8100, 1);
    ctl("R6", 16'hC001, 0);
    ctl("R6", 16'h0080, 0);

    // R8: collision set, status read reports and clears, hit wins
    cyc("R8", 0, 0, 0, 0, 0, 1, 0);
    chk("R8", "collision bit", int'(statusData[5]), 1);
    ctl("R8", 16'h1234, 0);
    cyc("R8", 0, 0, 1, 0, 0, 0, 0);
    cyc("R8", 0, 0, 0, 0, 0, 1, 0);
    cyc("R8", 0, 0, 1, 0, 0, 1, 0);
    cyc("R8", 0, 0, 1, 0, 0, 0, 0);

    // R11: control write wins over status read / data access
    cyc("R11", 1, 16'h2222, 1, 0, 0, 0, 0);
    cyc("R11", 1, 16'h0031, 0, 1, 0, 0, 0);
    cyc("R11", 1, 16'h3333, 0, 0, 1, 0, 0);
    idle("R11", 10);
    // R9: data write clears pending
    cyc("R9", 0, 0, 0, 0, 1, 0, 10);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule